// File: doc/BRIEF.md
# Programmable Timing State Sequencer

The sequencer walks through a small table of 16-bit state words held inside the block. Each word describes one step of a measurement sequence: how many ticks the step lasts, which of two time bases supplies those ticks, and the control levels to drive while the step is active. The controls are a primary and a secondary DAC enable, a test-set select, an output-latch enable and a 6-bit control code. The two time bases arrive as single-cycle enable strobes, a fast one and a slow one, both in the system clock domain.

A host writes and reads the table through a simple register port. The port has a 5-bit address, a write enable, write data and read data. A one-cycle start pulse launches a sequence at entry 0, and `busy` stays high while it runs. When a state with its end-of-sequence bit set completes, `busy` drops, `done` pulses for one cycle and every control output returns to zero. The table is frozen while a sequence runs: host writes are dropped and host reads return zero. If no entry carries the end-of-sequence bit, the run ends after the last table entry.

Top module: `step_sequencer`

## Requirements
- R1: After reset every table entry reads 0x0000, and `busy`, `done` and all control outputs are low.
- R2: While idle, a host write with `host_we` high stores `host_wdata` at `host_addr`. In the default configuration `host_rdata` shows the addressed entry combinationally, in the same cycle.
- R3: While `busy` is high, host writes leave the table unchanged and `host_rdata` is 0x0000 for every address.
- R4: A start pulse is taken only while idle. `busy` is high on the following clock edge, with entry 0 active. A start pulse while `busy` is high has no effect on the run.
- R5: Bits 15:11 of a state word hold a repeat value R, and the state lasts R+1 ticks. Bit 10 picks the time base: 0 counts `fast_tick`, 1 counts `slow_tick`. Strobes of the time base that is not selected are ignored.
- R6: A state with bit 9 set ends the sequence. It lasts exactly one `fast_tick`, whatever its repeat field and bit 10 hold.
- R7: While `busy` is high, the outputs follow the active word. `dac_pri_en` is bit 8. `dac_sec_en` is bit 8 AND `dac2_allow`. `test_set_sel` is bit 7. `latch_en` is bit 6. `state_ctl` is bits 5:0. While idle, all of these outputs are 0.
- R8: On the clock edge that ends the final state, `busy` falls and `done` rises. `done` is high for exactly one cycle.
- R9: If the last table entry completes without its bit 9 set, the sequence ends as if it were a stop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted when idle |
| fast_tick | input | 1 | Fast time-base enable strobe |
| slow_tick | input | 1 | Slow time-base enable strobe |
| dac2_allow | input | 1 | Static enable for the secondary DAC output |
| host_we | input | 1 | Host table write enable |
| host_addr | input | 5 | Host table entry address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, zero while busy |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| dac_pri_en | output | 1 | Primary DAC enable of the active state |
| dac_sec_en | output | 1 | Secondary DAC enable of the active state |
| test_set_sel | output | 1 | Test register-set select of the active state |
| latch_en | output | 1 | Output-latch enable of the active state |
| state_ctl | output | 6 | Control code of the active state |

## Verification
Each result has a fixed due time relative to its cause.
- Read data is combinational, so it is sampled shortly after the address is applied in the same cycle.
- A host write shows up once its clock edge has passed.
- `busy` and the first state's controls are valid one edge after the start pulse is sampled.
- Each state holds for exactly R+1 edges on which its time-base strobe is high.
- `done` rises on the same edge that drops `busy`, and clears one edge later.

The bench drives inputs and samples outputs at falling edges only. It counts the falling edges during which `busy` is high and compares that count with R+1 per state plus one for the stop state. With the fast strobe held high, a sequence therefore has a known length in cycles. The slow-base state is advanced one strobe at a time, and its outputs are checked between strobes.

// File: rtl/stseq_pkg.sv
package stseq_pkg;

   localparam int WORD_W = 16;
   localparam int REP_W  = 5;
   localparam int CTL_W  = 6;

   // Bit layout of one state word; field order is fixed by the host format.
   typedef struct packed {
      logic [REP_W-1:0] rep_cnt;    // 15:11 extra ticks beyond the first
      logic             slow_base;  // 10    1 = slow strobe
      logic             end_mark;   // 9     last state of the sequence
      logic             dac_on;     // 8
      logic             test_set;   // 7
      logic             latch_on;   // 6
      logic [CTL_W-1:0] ctl;        // 5:0
   } state_word_t;

endpackage

// File: rtl/stseq_table.sv
module stseq_table
   import stseq_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int ADDR_W  = 5,
   parameter bit RD_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   input  logic [ADDR_W-1:0] cur_idx,
   output state_word_t       cur_word
);

   logic [WORD_W-1:0] mem_q [ENTRIES];
   logic              addr_ok;
   logic [WORD_W-1:0] rd_word;

   assign addr_ok = ({1'b0, addr} < (ADDR_W+1)'(ENTRIES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && !lock && addr == ADDR_W'(i)) mem_q[i] <= wdata;
         end
      end
   end

   assign rd_word  = (addr_ok && !lock) ? mem_q[addr] : '0;
   assign cur_word = state_word_t'(mem_q[cur_idx]);

   generate
      if (RD_REG) begin : g_rd_reg
         logic [WORD_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rd_word;
         end
         assign rdata = rdata_q;
      end else begin : g_rd_comb
         assign rdata = rd_word;
      end
   endgenerate

   // R3: a write attempted while locked leaves the addressed entry as it was
   a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && wr_en && addr_ok) |=> (mem_q[$past(addr)] == $past(mem_q[addr])));

endmodule

// File: rtl/stseq_timer.sv
module stseq_timer
   import stseq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             fast_tick,
   input  logic             slow_tick,
   input  logic [REP_W-1:0] rep_cnt,
   input  logic             slow_base,
   input  logic             end_mark,
   output logic             expire
);

   logic [REP_W-1:0] cnt_q;
   logic [REP_W-1:0] limit;
   logic             tick;

   // A stop state always runs on the fast base for a single tick.
   assign tick   = end_mark ? fast_tick : (slow_base ? slow_tick : fast_tick);
   assign limit  = end_mark ? '0 : rep_cnt;
   assign expire = run && tick && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run || expire)  cnt_q <= '0;
      else if (tick)            cnt_q <= cnt_q + 1'b1;
   end

   // R5: the tick count never runs past the programmed repeat value
   a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= limit));

   // R6: a stop state is always in its first and only tick
   a_r6_stop_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (run && end_mark) |-> (cnt_q == '0));

endmodule

// File: rtl/stseq_ctrl.sv
module stseq_ctrl #(
   parameter int ENTRIES = 32,
   parameter int ADDR_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              expire,
   input  logic              end_mark,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] idx
);

   localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(ENTRIES - 1);

   logic              busy_q;
   logic              done_q;
   logic [ADDR_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               idx_q  <= '0;
            end
         end else if (expire) begin
            if (end_mark || idx_q == LAST_IDX) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               idx_q  <= '0;
            end else begin
               idx_q  <= idx_q + 1'b1;
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign idx  = idx_q;

   // R4: an idle start launches at entry 0 on the next edge
   a_r4_start_entry0: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && idx == '0));

   // R8: done only appears on the edge that ended a run
   a_r8_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R8: done lasts a single cycle
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: the index stays inside the table
   a_r9_idx_in_table: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ({1'b0, idx} <= {1'b0, LAST_IDX}));

endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
   import stseq_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter bit RD_REG  = 1'b0,
   localparam int ADDR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              fast_tick,
   input  logic              slow_tick,
   input  logic              dac2_allow,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   output logic              busy,
   output logic              done,
   output logic              dac_pri_en,
   output logic              dac_sec_en,
   output logic              test_set_sel,
   output logic              latch_en,
   output logic [CTL_W-1:0]  state_ctl
);

   generate
      if (ENTRIES < 3) begin : g_bad_depth
         $error("step_sequencer: ENTRIES must allow idle, work and stop states");
      end
      if (ENTRIES > 256) begin : g_big_depth
         $error("step_sequencer: ENTRIES above 256 not supported");
      end
      if ($bits(state_word_t) != WORD_W) begin : g_bad_word
         $error("step_sequencer: state word layout does not fill WORD_W");
      end
   endgenerate

   state_word_t       cur_word;
   logic [ADDR_W-1:0] cur_idx;
   logic              expire;
   logic              run;

   stseq_table #(
      .ENTRIES (ENTRIES),
      .ADDR_W  (ADDR_W),
      .RD_REG  (RD_REG)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock     (run),
      .wr_en    (host_we),
      .addr     (host_addr),
      .wdata    (host_wdata),
      .rdata    (host_rdata),
      .cur_idx  (cur_idx),
      .cur_word (cur_word)
   );

   stseq_timer u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .fast_tick (fast_tick),
      .slow_tick (slow_tick),
      .rep_cnt   (cur_word.rep_cnt),
      .slow_base (cur_word.slow_base),
      .end_mark  (cur_word.end_mark),
      .expire    (expire)
   );

   stseq_ctrl #(
      .ENTRIES (ENTRIES),
      .ADDR_W  (ADDR_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .expire   (expire),
      .end_mark (cur_word.end_mark),
      .busy     (run),
      .done     (done),
      .idx      (cur_idx)
   );

   assign busy         = run;
   assign dac_pri_en   = run & cur_word.dac_on;
   assign dac_sec_en   = run & cur_word.dac_on & dac2_allow;
   assign test_set_sel = run & cur_word.test_set;
   assign latch_en     = run & cur_word.latch_on;
   assign state_ctl    = run ? cur_word.ctl : '0;

   // R7: the secondary enable needs both the primary enable and the static allow
   a_r7_sec_needs_pri: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sec_en |-> (dac_pri_en && dac2_allow));

   // R7: nothing is driven between runs
   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ({dac_pri_en, dac_sec_en, test_set_sel, latch_en, state_ctl} == '0));

endmodule

// File: tb/step_sequencer_tb.sv
module step_sequencer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        fast_tick = 1'b0;
   logic        slow_tick = 1'b0;
   logic        dac2_allow = 1'b0;
   logic        host_we = 1'b0;
   logic [4:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        busy, done, dac_pri_en, dac_sec_en, test_set_sel, latch_en;
   logic [5:0]  state_ctl;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   step_sequencer u_dut (
      .clk (clk), .rst_n (rst_n), .start (start),
      .fast_tick (fast_tick), .slow_tick (slow_tick), .dac2_allow (dac2_allow),
      .host_we (host_we), .host_addr (host_addr), .host_wdata (host_wdata),
      .host_rdata (host_rdata), .busy (busy), .done (done),
      .dac_pri_en (dac_pri_en), .dac_sec_en (dac_sec_en),
      .test_set_sel (test_set_sel), .latch_en (latch_en), .state_ctl (state_ctl)
   );

   // {word[15:0], dac2_allow, expected {pri,sec,tsel,latch,ctl[5:0]}, expected busy cycles}
   localparam int NV = 6;
   localparam logic [34:0] VEC [NV] = '{
      {16'h0000, 1'b0, 10'h000, 8'd2},
      {16'h1940, 1'b1, 10'h340, 8'd5},
      {16'h0100, 1'b0, 10'h200, 8'd2},
      {16'h38AA, 1'b1, 10'h0AA, 8'd9},
      {16'hF83F, 1'b0, 10'h03F, 8'd33},
      {16'h0840, 1'b1, 10'h040, 8'd3}
   };
   localparam logic [15:0] STOP_WORD = 16'hFE15; // stop, repeat 31, slow base, ctl 0x15

   function automatic logic [9:0] outs();
      return {dac_pri_en, dac_sec_en, test_set_sel, latch_en, state_ctl};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [4:0] a, input logic [15:0] exp, input string req);
      host_addr = a;
      #1;
      chk(host_rdata == exp, req, host_rdata, exp);
   endtask

   // Pulses start, counts falling edges with busy high, captures the first state's outputs.
   task automatic run_seq(output int len, output logic [9:0] first_out);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      len = 0;
      first_out = outs();
      while (busy && len < 1000) begin
         len++;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int len;
      logic [9:0] fo;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
      chk(outs() == '0, "R1 outputs", outs(), 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk(5'd0, 16'h0000, "R1 entry0");
      rd_chk(5'd31, 16'h0000, "R1 entry31");

      // R2: idle write and read back
      wr(5'd3, 16'hA5C3);
      rd_chk(5'd3, 16'hA5C3, "R2 readback");

      // Vector walk: R5 duration, R6 stop length, R7 decode, R8 done
      fast_tick = 1'b1;
      wr(5'd1, STOP_WORD);
      for (int v = 0; v < NV; v++) begin
         wr(5'd0, VEC[v][34:19]);
         dac2_allow = VEC[v][18];
         run_seq(len, fo);
         chk(fo == VEC[v][17:8], "R7 state outputs", fo, VEC[v][17:8]);
         chk(len == int'(VEC[v][7:0]), "R5 R6 busy length", len, VEC[v][7:0]);
         chk(done == 1'b1, "R8 done with busy fall", done, 1);
         chk(outs() == '0, "R7 idle outputs", outs(), 0);
         @(negedge clk);
         chk(done == 1'b0, "R8 done one cycle", done, 0);
      end

      // R3 and R4: locked table, start ignored while busy
      wr(5'd0, 16'h1840);
      wr(5'd1, 16'h0200);
      host_addr = 5'd0;
      @(negedge clk) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R4 busy after start", busy, 1);
      #1;
      chk(host_rdata == 16'h0000, "R3 read zero while busy", host_rdata, 0);
      host_we = 1'b1; host_wdata = 16'hFFFF; start = 1'b1;
      @(negedge clk);
      host_we = 1'b0; start = 1'b0;
      len = 1;
      while (busy && len < 1000) begin
         len++;
         @(negedge clk);
      end
      chk(len == 5, "R4 restart ignored", len, 5);
      rd_chk(5'd0, 16'h1840, "R3 write ignored while busy");

      // R5 slow base and R6 stop on fast tick
      wr(5'd0, 16'h1401);
      wr(5'd1, STOP_WORD);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (5) @(negedge clk);
      chk(busy && state_ctl == 6'h01, "R5 fast strobes ignored", state_ctl, 1);
      for (int p = 0; p < 3; p++) begin
         slow_tick = 1'b1;
         @(negedge clk);
         slow_tick = 1'b0;
         if (p == 1) chk(state_ctl == 6'h01, "R5 two slow ticks not enough", state_ctl, 1);
      end
      chk(busy && state_ctl == 6'h15, "R6 stop state active", state_ctl, 6'h15);
      @(negedge clk);
      chk(!busy && done, "R6 stop lasts one fast tick", {busy, done}, 1);

      // R9: no stop bit anywhere
      for (int e = 0; e < 32; e++) wr(5'(e), 16'h0001);
      run_seq(len, fo);
      chk(len == 32, "R9 run ends after last entry", len, 32);
      chk(done == 1'b1, "R9 done after overrun", done, 1);
      @(negedge clk);
      chk(!busy && outs() == '0, "R7 idle after overrun", outs(), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule